// File: doc/BRIEF.md
# Store Buffer with Load Forwarding

This block sits between one in-order core and shared memory, and gives that core a total-store-order view of memory. Stores from the core are queued in a small first-in first-out buffer and count as finished as soon as they are queued. A write port to memory then retires the queued stores one at a time, oldest first.

Loads are not queued. When a load is accepted, every entry in the buffer is compared with its address at once. If one or more pending stores match, the load gets the data of the youngest matching store, and memory is not read. If none match, the load goes to memory through a separate read port, even if older stores to other addresses are still waiting. That load-before-store overtaking is the only reordering the block allows.

A fence request also covers locked accesses. While it is raised, the core is held until the buffer has fully drained. Only one load is in flight at a time, so loads leave in program order.

Top module: `store_order_buffer`

## Requirements
- R1: A store is accepted (`st_valid` and `st_ready` both high at a clock edge) whenever fewer than DEPTH entries are held and no fence is raised. It is complete at that edge and needs no memory write first. DEPTH defaults to 4.
- R2: While DEPTH entries are held, `st_ready` is low. It stays low until an entry drains.
- R3: The oldest entry is offered on `mw_valid`/`mw_addr`/`mw_data`, and `mw_valid` is low when the buffer is empty. Entries retire in the order they were accepted, at most one per cycle. The address and data hold steady while `mw_ready` is low.
- R4: A load whose address matches one or more held entries returns the data of the most recently accepted matching entry. It makes no memory read, and `ld_resp_valid` is high in the cycle after the load is accepted.
- R5: A load with no matching entry raises `mr_valid` with its address. It returns `mr_rdata` in the cycle after the cycle in which `mr_rvalid` is high.
- R6: A load that misses completes while older stores to other addresses are still held and undrained.
- R7: `mr_valid` is never high in a cycle where `mw_valid` and `mw_ready` are both high. The drain write wins the memory port.
- R8: At most one load is in flight. `ld_ready` is low from the edge that accepts a load until the response cycle has passed. `ld_ready` is also low while `st_valid` is high, so a store shown in the same cycle counts as the older operation.
- R9: While `fence_valid` is high, both `st_ready` and `ld_ready` are low. `fence_ready` is high only when the buffer is empty and no load is in flight.
- R10: After reset the buffer is empty: `st_ready`, `ld_ready` and `fence_ready` are high, and `mw_valid` and `ld_resp_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Core presents a store |
| st_ready | output | 1 | Buffer can take the store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| ld_valid | input | 1 | Core presents a load |
| ld_ready | output | 1 | Load can be accepted |
| ld_addr | input | AW | Load address |
| ld_resp_valid | output | 1 | Load result is valid this cycle |
| ld_resp_data | output | DW | Load result |
| fence_valid | input | 1 | Fence or locked access requested |
| fence_ready | output | 1 | Buffer empty and no load in flight |
| mw_valid | output | 1 | Drain write offered to memory |
| mw_ready | input | 1 | Memory takes the drain write |
| mw_addr | output | AW | Drain write address |
| mw_data | output | DW | Drain write data |
| mr_valid | output | 1 | Memory read request for a missing load |
| mr_ready | input | 1 | Memory takes the read request |
| mr_addr | output | AW | Memory read address |
| mr_rvalid | input | 1 | Memory read data valid |
| mr_rdata | input | DW | Memory read data |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is a drain write and a pending load miss. The bench first parks two stores while memory refuses writes. It then opens the write port and issues a miss one edge later. In the following cycle it confirms that the drain handshake is in progress and that the read request is held low. The read must then follow once the buffer is empty, and the scoreboard compares the returned value.

The second pair is forwarding and draining. The bench issues loads to recently stored addresses while `mw_ready` toggles pseudo-randomly. The expected value is taken from the bench's own list of undrained stores at the accepting edge, or from its memory model if no undrained store matches. So an entry that retires at the same edge must still give the same data.

// File: rtl/sob_pkg.sv
package sob_pkg;

    typedef enum logic [1:0] {
        LD_IDLE  = 2'd0,
        LD_ISSUE = 2'd1,
        LD_WAIT  = 2'd2,
        LD_RESP  = 2'd3
    } ld_state_e;

endpackage

// File: rtl/sob_fifo.sv
module sob_fifo #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [AW-1:0]              push_addr,
    input  logic [DW-1:0]              push_data,
    input  logic                       pop,
    output logic [$clog2(DEPTH)-1:0]   head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic [AW-1:0]              ent_addr [DEPTH],
    output logic [DW-1:0]              ent_data [DEPTH]
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] head;
        logic [PW-1:0] tail;
        logic [CW-1:0] count;
    } ctl_t;

    ctl_t          ctl_d, ctl_q;
    logic [AW-1:0] addr_d [DEPTH];
    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_d [DEPTH];
    logic [DW-1:0] data_q [DEPTH];

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        ctl_d  = ctl_q;
        addr_d = addr_q;
        data_d = data_q;
        if (push) begin
            addr_d[ctl_q.tail] = push_addr;
            data_d[ctl_q.tail] = push_data;
            ctl_d.tail         = step(ctl_q.tail);
        end
        if (pop) begin
            ctl_d.head = step(ctl_q.head);
        end
        case ({push, pop})
            2'b10:   ctl_d.count = ctl_q.count + 1'b1;
            2'b01:   ctl_d.count = ctl_q.count - 1'b1;
            default: ctl_d.count = ctl_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                addr_q[i] <= '0;
                data_q[i] <= '0;
            end
        end else begin
            ctl_q  <= ctl_d;
            addr_q <= addr_d;
            data_q <= data_d;
        end
    end

    assign head     = ctl_q.head;
    assign count    = ctl_q.count;
    assign ent_addr = addr_q;
    assign ent_data = data_q;

endmodule

// File: rtl/sob_fwd.sv
module sob_fwd #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic [$clog2(DEPTH)-1:0]   head,
    input  logic [$clog2(DEPTH+1)-1:0] count,
    input  logic [AW-1:0]              ent_addr [DEPTH],
    input  logic [DW-1:0]              ent_data [DEPTH],
    input  logic [AW-1:0]              probe_addr,
    output logic                       hit,
    output logic [DW-1:0]              hit_data
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    // age 0 is the oldest held entry; slot maps an age to a storage index
    logic [PW:0]      sum  [DEPTH];
    logic [PW-1:0]    slot [DEPTH];
    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_age
        assign sum[g]   = {1'b0, head} + (PW+1)'(g);
        assign slot[g]  = (sum[g] >= (PW+1)'(DEPTH)) ? PW'(sum[g] - (PW+1)'(DEPTH))
                                                      : sum[g][PW-1:0];
        assign match[g] = (CW'(g) < count) && (ent_addr[slot[g]] == probe_addr);
    end

    // later ages overwrite earlier ones, so the youngest match wins
    always_comb begin
        hit      = |match;
        hit_data = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (match[i]) begin
                hit_data = ent_data[slot[i]];
            end
        end
    end

endmodule

// File: rtl/sob_ldctl.sv
module sob_ldctl
    import sob_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_valid,
    input  logic          ld_ok,
    input  logic [AW-1:0] ld_addr,
    input  logic          fwd_hit,
    input  logic [DW-1:0] fwd_data,
    input  logic          port_busy,
    input  logic          mr_ready,
    input  logic          mr_rvalid,
    input  logic [DW-1:0] mr_rdata,
    output logic          ld_ready,
    output logic          idle,
    output logic          mr_valid,
    output logic [AW-1:0] mr_addr,
    output logic          ld_resp_valid,
    output logic [DW-1:0] ld_resp_data
);
    typedef struct packed {
        ld_state_e     st;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } ld_t;

    ld_t ld_d, ld_q;

    assign idle          = (ld_q.st == LD_IDLE);
    assign ld_ready      = idle && ld_ok;
    assign mr_valid      = (ld_q.st == LD_ISSUE) && !port_busy;
    assign mr_addr       = ld_q.addr;
    assign ld_resp_valid = (ld_q.st == LD_RESP);
    assign ld_resp_data  = ld_q.data;

    always_comb begin
        ld_d = ld_q;
        case (ld_q.st)
            LD_IDLE: begin
                if (ld_valid && ld_ready) begin
                    ld_d.addr = ld_addr;
                    if (fwd_hit) begin
                        ld_d.data = fwd_data;
                        ld_d.st   = LD_RESP;
                    end else begin
                        ld_d.st   = LD_ISSUE;
                    end
                end
            end
            LD_ISSUE: begin
                if (mr_valid && mr_ready) begin
                    ld_d.st = LD_WAIT;
                end
            end
            LD_WAIT: begin
                if (mr_rvalid) begin
                    ld_d.data = mr_rdata;
                    ld_d.st   = LD_RESP;
                end
            end
            default: ld_d.st = LD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q <= '{st: LD_IDLE, addr: '0, data: '0};
        end else begin
            ld_q <= ld_d;
        end
    end

endmodule

// File: rtl/store_order_buffer.sv
module store_order_buffer #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          st_valid,
    output logic          st_ready,
    input  logic [AW-1:0] st_addr,
    input  logic [DW-1:0] st_data,
    input  logic          ld_valid,
    output logic          ld_ready,
    input  logic [AW-1:0] ld_addr,
    output logic          ld_resp_valid,
    output logic [DW-1:0] ld_resp_data,
    input  logic          fence_valid,
    output logic          fence_ready,
    output logic          mw_valid,
    input  logic          mw_ready,
    output logic [AW-1:0] mw_addr,
    output logic [DW-1:0] mw_data,
    output logic          mr_valid,
    input  logic          mr_ready,
    output logic [AW-1:0] mr_addr,
    input  logic          mr_rvalid,
    input  logic [DW-1:0] mr_rdata
);
    localparam int PW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0] head;
    logic [CW-1:0] count;
    logic [AW-1:0] ent_addr [DEPTH];
    logic [DW-1:0] ent_data [DEPTH];
    logic          push, pop;
    logic          fwd_hit;
    logic [DW-1:0] fwd_data;
    logic          ld_idle;

    assign st_ready    = (count != CW'(DEPTH)) && !fence_valid;
    assign push        = st_valid && st_ready;
    assign mw_valid    = (count != '0);
    assign mw_addr     = ent_addr[head];
    assign mw_data     = ent_data[head];
    assign pop         = mw_valid && mw_ready;
    assign fence_ready = (count == '0) && ld_idle;

    sob_fifo #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_addr (st_addr),
        .push_data (st_data),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .ent_addr  (ent_addr),
        .ent_data  (ent_data)
    );

    sob_fwd #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_fwd (
        .head       (head),
        .count      (count),
        .ent_addr   (ent_addr),
        .ent_data   (ent_data),
        .probe_addr (ld_addr),
        .hit        (fwd_hit),
        .hit_data   (fwd_data)
    );

    sob_ldctl #(.AW(AW), .DW(DW)) u_ldctl (
        .clk           (clk),
        .rst_n         (rst_n),
        .ld_valid      (ld_valid),
        .ld_ok         (!st_valid && !fence_valid),
        .ld_addr       (ld_addr),
        .fwd_hit       (fwd_hit),
        .fwd_data      (fwd_data),
        .port_busy     (pop),
        .mr_ready      (mr_ready),
        .mr_rvalid     (mr_rvalid),
        .mr_rdata      (mr_rdata),
        .ld_ready      (ld_ready),
        .idle          (ld_idle),
        .mr_valid      (mr_valid),
        .mr_addr       (mr_addr),
        .ld_resp_valid (ld_resp_valid),
        .ld_resp_data  (ld_resp_data)
    );

endmodule

// File: rtl/sob_checker.sv
module sob_checker #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          st_valid,
    input logic          st_ready,
    input logic          ld_valid,
    input logic          ld_ready,
    input logic          ld_resp_valid,
    input logic          fence_valid,
    input logic          fence_ready,
    input logic          mw_valid,
    input logic          mw_ready,
    input logic [AW-1:0] mw_addr,
    input logic [DW-1:0] mw_data,
    input logic          mr_valid
);
    localparam int OW = $clog2(DEPTH + 1) + 1;

    // occupancy rebuilt from port handshakes only
    logic [OW-1:0] occ_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            occ_q <= '0;
        end else begin
            occ_q <= occ_q + OW'(st_valid && st_ready) - OW'(mw_valid && mw_ready);
        end
    end

    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occ_q <= OW'(DEPTH));

    assert_accept_room_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q < OW'(DEPTH)) && !fence_valid |-> st_ready);

    assert_full_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == OW'(DEPTH)) |-> !st_ready);

    assert_empty_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (occ_q == '0) |-> !mw_valid);

    assert_drain_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

    assert_write_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mr_valid && mw_valid && mw_ready));

    assert_single_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && ld_ready |=> !ld_ready);

    assert_no_resp_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ld_valid && ld_ready |-> !ld_resp_valid);

    assert_fence_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fence_ready |-> (occ_q == '0));

    assert_fence_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        fence_valid |-> !st_ready && !ld_ready);

endmodule

bind store_order_buffer sob_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .st_valid      (st_valid),
    .st_ready      (st_ready),
    .ld_valid      (ld_valid),
    .ld_ready      (ld_ready),
    .ld_resp_valid (ld_resp_valid),
    .fence_valid   (fence_valid),
    .fence_ready   (fence_ready),
    .mw_valid      (mw_valid),
    .mw_ready      (mw_ready),
    .mw_addr       (mw_addr),
    .mw_data       (mw_data),
    .mr_valid      (mr_valid)
);

// File: tb/test_store_order_buffer.sv
`timescale 1ns/1ps
module test_store_order_buffer;
    localparam int DEPTH = 4;
    localparam int AW    = 8;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          st_valid = 1'b0, st_ready;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic          ld_valid = 1'b0, ld_ready;
    logic [AW-1:0] ld_addr = '0;
    logic          ld_resp_valid;
    logic [DW-1:0] ld_resp_data;
    logic          fence_valid = 1'b0, fence_ready;
    logic          mw_valid, mw_ready = 1'b0;
    logic [AW-1:0] mw_addr;
    logic [DW-1:0] mw_data;
    logic          mr_valid, mr_ready = 1'b1;
    logic [AW-1:0] mr_addr;
    logic          mr_rvalid = 1'b0;
    logic [DW-1:0] mr_rdata = '0;

    always #2.5 clk = ~clk;

    store_order_buffer #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) i_store_order_buffer (.*);

    int checks = 0, fails = 0;
    int mode = 0;            // 0: writes refused, 1: writes taken, 2: pseudo-random
    int mr_hs = 0;
    bit ld_pend = 0;
    logic [15:0] wr_lfsr = 16'hACE1;
    logic [15:0] op_lfsr = 16'h1D2B;
    logic [DW-1:0] mem [256];
    logic [AW-1:0] q_addr [$];
    logic [DW-1:0] q_data [$];
    logic [DW-1:0] r_exp [$];
    string         r_tag [$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // memory model: write readiness and read responses
    always @(posedge clk) begin
        wr_lfsr <= {wr_lfsr[14:0], wr_lfsr[15] ^ wr_lfsr[13] ^ wr_lfsr[12] ^ wr_lfsr[10]};
        case (mode)
            0:       mw_ready <= 1'b0;
            1:       mw_ready <= 1'b1;
            default: mw_ready <= wr_lfsr[0];
        endcase
        mr_rvalid <= mr_valid && mr_ready;
        mr_rdata  <= mem[mr_addr];
        if (mr_valid && mr_ready) mr_hs++;
    end

    // monitor: drain order, port priority, load results
    always @(negedge clk) begin
        if (rst_n) begin
            if (mw_valid && mw_ready) begin
                if (q_addr.size() == 0) begin
                    chk(0, "R3", "drain with nothing queued", longint'(mw_addr), 0);
                end else begin
                    chk(mw_addr == q_addr[0] && mw_data == q_data[0], "R3", "drain order",
                        longint'({mw_addr, mw_data}), longint'({q_addr[0], q_data[0]}));
                    mem[mw_addr] = mw_data;
                    void'(q_addr.pop_front());
                    void'(q_data.pop_front());
                end
                if (ld_pend) chk(!mr_valid, "R7", "read during drain write", longint'(mr_valid), 0);
            end
            if (ld_resp_valid) begin
                if (r_exp.size() == 0) begin
                    chk(0, "R5", "unexpected load response", longint'(ld_resp_data), 0);
                end else begin
                    chk(ld_resp_data == r_exp[0], r_tag[0], "load data",
                        longint'(ld_resp_data), longint'(r_exp[0]));
                    void'(r_exp.pop_front());
                    void'(r_tag.pop_front());
                end
                ld_pend = 0;
            end
        end
    end

    task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        st_valid = 1'b1; st_addr = a; st_data = d;
        do @(posedge clk); while (!st_ready);
        q_addr.push_back(a);
        q_data.push_back(d);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic do_load(input logic [AW-1:0] a, input string tag);
        logic [DW-1:0] e;
        bit found;
        @(negedge clk);
        ld_valid = 1'b1; ld_addr = a;
        do @(posedge clk); while (!ld_ready);
        found = 0;
        e = mem[a];
        for (int i = q_addr.size() - 1; i >= 0; i--) begin
            if (!found && q_addr[i] == a) begin
                e = q_data[i];
                found = 1;
            end
        end
        r_exp.push_back(e);
        r_tag.push_back(tag);
        ld_pend = 1;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    task automatic wait_resp();
        while (ld_pend) @(negedge clk);
    endtask

    task automatic run_all();
        int hs0;
        for (int i = 0; i < 256; i++) mem[i] = 16'hA000 | DW'(i);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 reset state
        @(negedge clk);
        chk(st_ready, "R10", "st_ready", longint'(st_ready), 1);
        chk(ld_ready && fence_ready, "R10", "ld/fence ready", longint'({ld_ready, fence_ready}), 3);
        chk(!mw_valid && !ld_resp_valid, "R10", "quiet outputs", longint'({mw_valid, ld_resp_valid}), 0);

        // R1/R2 fill while memory refuses writes
        do_store(8'h10, 16'h1111);
        do_store(8'h20, 16'h2222);
        do_store(8'h10, 16'h3333);
        do_store(8'h30, 16'h4444);
        @(negedge clk);
        chk(q_addr.size() == 4, "R1", "stores complete before memory write", q_addr.size(), 4);
        chk(!st_ready, "R2", "st_ready when full", longint'(st_ready), 0);

        // R4 youngest match forwarded, no memory read
        hs0 = mr_hs;
        do_load(8'h10, "R4");
        wait_resp();
        chk(mr_hs == hs0, "R4", "memory reads on hit", mr_hs, hs0);

        // R5/R6 miss completes past held stores
        do_load(8'h55, "R5");
        wait_resp();
        chk(mw_valid && q_addr.size() == 4, "R6", "stores still held after miss",
            q_addr.size(), 4);

        // R8 single load in flight; store priority
        mr_ready = 1'b0;
        do_load(8'h66, "R5");
        chk(!ld_ready, "R8", "ld_ready with load in flight", longint'(ld_ready), 0);
        mr_ready = 1'b1;
        wait_resp();
        @(negedge clk);
        st_valid = 1'b1; st_addr = 8'h99;
        #0.1;
        chk(!ld_ready, "R8", "ld_ready while store shown", longint'(ld_ready), 0);
        @(negedge clk);
        st_valid = 1'b0;

        // R9 fence drains everything; R2 lifted by drain
        @(negedge clk);
        fence_valid = 1'b1;
        #0.1;
        chk(!fence_ready, "R9", "fence_ready with entries", longint'(fence_ready), 0);
        chk(!ld_ready && !st_ready, "R9", "core held by fence", longint'({ld_ready, st_ready}), 0);
        mode = 1;
        while (!fence_ready) @(negedge clk);
        chk(q_addr.size() == 0, "R9", "entries left at fence", q_addr.size(), 0);
        chk(mem[8'h10] == 16'h3333, "R3", "last write wins in memory",
            longint'(mem[8'h10]), 16'h3333);
        @(negedge clk);
        fence_valid = 1'b0;

        // R7 drain write beats a pending miss
        mode = 0;
        @(posedge clk);
        do_store(8'h40, 16'h5151);
        do_store(8'h41, 16'h5252);
        mode = 1;
        @(posedge clk);
        do_load(8'h77, "R5");
        chk(mw_valid && mw_ready, "R7", "drain active", longint'({mw_valid, mw_ready}), 3);
        chk(!mr_valid, "R7", "read held behind drain", longint'(mr_valid), 0);
        wait_resp();

        // mixed traffic, random write readiness
        mode = 2;
        for (int n = 0; n < 80; n++) begin
            op_lfsr = {op_lfsr[14:0], op_lfsr[15] ^ op_lfsr[13] ^ op_lfsr[12] ^ op_lfsr[10]};
            if (op_lfsr[0]) do_store(8'h80 | AW'(op_lfsr[2:1]), DW'(16'h6000 + n));
            else            do_load(8'h80 | AW'(op_lfsr[4:3]), "R4");
        end
        wait_resp();
        mode = 1;
        @(negedge clk);
        fence_valid = 1'b1;
        while (!fence_ready) @(negedge clk);
        chk(q_addr.size() == 0, "R9", "final drain", q_addr.size(), 0);
        @(negedge clk);
        fence_valid = 1'b0;
        chk(r_exp.size() == 0, "R5", "responses outstanding", r_exp.size(), 0);
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(0, "watchdog", "run did not finish", 0, 1);
            end
        join_any
        disable fork;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule